// File: doc/BRIEF.md
# Maskable Link-Event Interrupt Controller

This block watches four level signals coming from the link logic of an Ethernet physical-layer device: an auto-negotiation done flag, the current speed, the current duplex mode and the link state. It turns changes on those levels into events. Each event sets a sticky bit in a status register, and the bit stays set until software reads that register. A mask register selects which sticky bits count toward a pending summary. A separate enable bit decides whether that summary drives the active-low interrupt output.

Software reaches both registers through a simple single-cycle register port. A select line picks the mask or the status register. Read data is combinational on the cycle the read strobe is high. A status read clears the sticky bits at the next clock edge. An event that lands on the same clock edge as that clear is kept for the following read. The interrupt output models an open-drain pin: 0 pulls the line low and 1 is the released state.

Top module: `link_evt_irq`

## Requirements
- R1: After reset the mask register reads 0x0000, the status register reads 0x0000 and irq_n_o is 1.
- R2: A change of link_i in either direction sets status bit 4, a change of speed_i sets bit 6 and a change of duplex_i sets bit 5. Each bit is set at the first clock edge that samples the new level.
- R3: A rising edge of an_done_i sets status bit 7. A falling edge of an_done_i sets nothing.
- R4: A status bit stays set until the status register is read (reg_rd_i=1, reg_sel_i=1). At the clock edge of that read the bit clears.
- R5: An event detected at the same clock edge as a status read stays set after that edge. The next status read returns it.
- R6: Status bit 2 (pending) reads 1 exactly when some status bit in 7:4 is set and the mask bit at the same position is 1.
- R7: irq_n_o is 0 exactly when pending is 1 and mask bit 1 (interrupt enable) is 1. A status read that clears the pending sources returns irq_n_o to 1 after its clock edge.
- R8: Only mask bits 7:4 and 1 are writable. Every other bit of either register reads 0, and writes to those bits have no effect. Reading the mask register does not change the status register.
- R9: A level that is already present when reset is released produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| an_done_i | input | 1 | Auto-negotiation done level |
| speed_i | input | 1 | Speed level |
| duplex_i | input | 1 | Duplex level |
| link_i | input | 1 | Link-up level |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_sel_i | input | 1 | Register select: 0 mask, 1 status |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, valid while reg_rd_i is 1 |
| irq_n_o | output | 1 | Active-low interrupt, 1 = released |

## Verification
An input change made before a clock edge is recorded at that edge. Status bits, pending and irq_n_o therefore show it one edge later. The bench changes inputs on falling edges and checks at the following falling edge. Read data is combinational, so the bench samples it 1 ns after raising the read strobe, before the clearing edge. It checks the cleared state at the falling edge that follows. A mask write takes effect at its edge, and the bench waits that one edge before it looks at the interrupt.

// File: rtl/link_evt_irq_pkg.sv
package link_evt_irq_pkg;
  localparam int DW      = 16;
  localparam int NSRC    = 4;
  localparam int B_LINK  = 4;   // sources occupy bits B_LINK .. B_LINK+NSRC-1
  localparam int B_PEND  = 2;
  localparam int B_EN    = 1;

  // Keep only the writable mask bits.
  function automatic logic [DW-1:0] keep_mask_bits(input logic [DW-1:0] w);
    logic [DW-1:0] k;
    k = '0;
    k[B_LINK +: NSRC] = w[B_LINK +: NSRC];
    k[B_EN] = w[B_EN];
    return k;
  endfunction

  // Summary of enabled sticky sources.
  function automatic logic any_enabled(input logic [NSRC-1:0] st,
                                       input logic [NSRC-1:0] en);
    return |(st & en);
  endfunction
endpackage

// File: rtl/lvl_change_det.sv
module lvl_change_det #(
  parameter bit BOTH_EDGES = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed_i,
  input  logic lvl_i,
  output logic evt_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  generate
    if (BOTH_EDGES) begin : g_both
      assign evt_o = armed_i && (lvl_i != prev_q);
    end else begin : g_rise
      assign evt_o = armed_i && lvl_i && !prev_q;
    end
  endgenerate

  // R9
  unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_i |-> !evt_o);

  generate
    if (!BOTH_EDGES) begin : g_rise_chk
      // R3
      fall_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_q && !lvl_i) |-> !evt_o);
    end
  endgenerate
endmodule

// File: rtl/sticky_status.sv
module sticky_status #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic         clr_i,
  output logic [N-1:0] sticky_o
);
  logic [N-1:0] st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= '0;
    else if (clr_i) st_q <= evt_i;
    else            st_q <= st_q | evt_i;
  end

  assign sticky_o = st_q;

  // R4
  hold_until_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((st_q & $past(st_q)) == $past(st_q)));
  // R2
  event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & $past(evt_i)) == $past(evt_i)));
  // R5
  clear_keeps_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (st_q == $past(evt_i)));
endmodule

// File: rtl/link_evt_irq.sv
module link_evt_irq
  import link_evt_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          an_done_i,
  input  logic          speed_i,
  input  logic          duplex_i,
  input  logic          link_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic          reg_sel_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_n_o
);
  // source order: link, duplex, speed, an_done (bits 4..7)
  logic [NSRC-1:0] lvl, evt, sticky;
  logic [DW-1:0]   mask_q;
  logic            armed_q, pending, irq_act, stat_clr;

  assign lvl = {an_done_i, speed_i, duplex_i, link_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_det
      lvl_change_det #(.BOTH_EDGES(i != NSRC-1)) u_det (
        .clk(clk), .rst_n(rst_n), .armed_i(armed_q),
        .lvl_i(lvl[i]), .evt_o(evt[i]));
    end
  endgenerate

  assign stat_clr = reg_rd_i && reg_sel_i;

  sticky_status #(.N(NSRC)) u_stat (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .clr_i(stat_clr), .sticky_o(sticky));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     mask_q <= '0;
    else if (reg_wr_i && !reg_sel_i) mask_q <= keep_mask_bits(reg_wdata_i);
  end

  assign pending = any_enabled(sticky, mask_q[B_LINK +: NSRC]);
  assign irq_act = pending && mask_q[B_EN];
  assign irq_n_o = !irq_act;

  always_comb begin
    reg_rdata_o = '0;
    if (reg_sel_i) begin
      reg_rdata_o[B_LINK +: NSRC] = sticky;
      reg_rdata_o[B_PEND]         = pending;
    end else begin
      reg_rdata_o = mask_q;
    end
  end

  // R7
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n_o |-> mask_q[B_EN]);
  // R7
  read_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !reg_wr_i && evt == '0) |=> irq_n_o);
  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q & ~keep_mask_bits('1)) == '0);
  // R8
  mask_read_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_i && !reg_sel_i) |=> ((sticky & $past(sticky)) == $past(sticky)));
endmodule

// File: tb/link_evt_irq_test.sv
`timescale 1ns/1ps
module link_evt_irq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic an_done_i = 0, speed_i = 0, duplex_i = 0, link_i = 0;
  logic reg_wr_i = 0, reg_rd_i = 0, reg_sel_i = 0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic irq_n_o;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz

  link_evt_irq uut (.*);

  // vector: levels {an,spd,dup,lnk}, mask, expected status, expected irq_n
  typedef struct packed { logic [3:0] lv; logic [15:0] mask; logic [15:0] st; logic irqn; } vec_t;
  localparam vec_t VECS [8] = '{
    '{4'b0001, 16'h00F2, 16'h0014, 1'b0},  // R2 link rise
    '{4'b0000, 16'h00F2, 16'h0014, 1'b0},  // R2 link fall
    '{4'b1000, 16'h0082, 16'h0084, 1'b0},  // R3 an rise
    '{4'b0000, 16'h00F2, 16'h0000, 1'b1},  // R3 an fall ignored
    '{4'b0100, 16'h0010, 16'h0040, 1'b1},  // R6 speed, masked
    '{4'b0110, 16'h0020, 16'h0024, 1'b1},  // R7 duplex pending, enable off
    '{4'b0010, 16'h0042, 16'h0044, 1'b0},  // R2 speed fall
    '{4'b1011, 16'h0012, 16'h0094, 1'b0}   // R6 an+link, link enabled
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_mask(input logic [15:0] d);
    @(negedge clk); reg_wr_i = 1; reg_sel_i = 0; reg_wdata_i = d;
    @(negedge clk); reg_wr_i = 0;
  endtask

  task automatic rd_reg(input logic sel, output logic [15:0] d);
    @(negedge clk); reg_rd_i = 1; reg_sel_i = sel;
    #1 d = reg_rdata_o;
    @(negedge clk); reg_rd_i = 0;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    link_i = 1;  // R9: level present during reset
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irq_n", {15'b0, irq_n_o}, 16'h1);
    rd_reg(0, d); check("R1 mask", d, 16'h0000);
    rd_reg(1, d); check("R9 no event from reset level", d, 16'h0000);
    link_i = 0;  // next line produces a link event; drop it
    @(negedge clk); rd_reg(1, d); check("R2 link fall after reset", d, 16'h0000 | 16'h0010);

    foreach (VECS[i]) begin
      wr_mask(VECS[i].mask);
      @(negedge clk);
      {an_done_i, speed_i, duplex_i, link_i} = VECS[i].lv;
      @(negedge clk);
      check($sformatf("R7 vec%0d irq_n", i), {15'b0, irq_n_o}, {15'b0, VECS[i].irqn});
      rd_reg(1, d);
      check($sformatf("R6 vec%0d status", i), d, VECS[i].st);
      check($sformatf("R4 vec%0d irq after read", i), {15'b0, irq_n_o}, 16'h1);
      rd_reg(1, d);
      check($sformatf("R4 vec%0d cleared", i), d, 16'h0000);
    end

    // R8 reserved bits
    wr_mask(16'hFFFF);
    rd_reg(0, d); check("R8 mask reserved", d, 16'h00F2);
    // R8 mask read keeps status
    @(negedge clk); link_i = ~link_i;
    @(negedge clk);
    rd_reg(0, d);
    rd_reg(1, d); check("R8 mask read no clear", d, 16'h0014);
    // R5 event in same cycle as read
    @(negedge clk); reg_rd_i = 1; reg_sel_i = 1; duplex_i = ~duplex_i;
    #1 d = reg_rdata_o; check("R5 read before event", d, 16'h0000);
    @(negedge clk); reg_rd_i = 0;
    check("R5 irq after same-cycle event", {15'b0, irq_n_o}, 16'h0);
    rd_reg(1, d); check("R5 event kept", d, 16'h0024);
    check("R7 released", {15'b0, irq_n_o}, 16'h1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule